// File: doc/BRIEF.md
# Page-Coalescing Store Write Buffer

This block sits between a processor's store port and a slower write-through memory port. Stores (address, data, byte enables) are queued in arrival order and retired one at a time over a valid/ready memory interface. How long a drain takes depends on where the store falls in memory. If the entry at the head of the queue lies on the same page as the store most recently retired, it is offered to memory at once, so a run of same-page stores retires one per clock. If it lies on a different page, or it is the first store since reset, it waits a configurable number of cycles before it is offered.

When every slot is taken, the core sees its store port not ready and must hold the store until a slot frees. Loads are not blocked by pending stores. A combinational lookup compares the load's word address with every pending entry and returns, byte by byte, the data of the youngest entry that writes that byte, together with a per-byte mask. The cache supplies any byte the mask leaves clear.

A parameter selects a reduced variant. It has four slots and no page tracking, so every drain takes the full slow latency.

Top module: `page_wbuf`

## Requirements
- R1: After reset, `buf_empty` is 1, `buf_full` is 0, `buf_count` is 0, `mem_valid` is 0 and `st_ready` is 1.
- R2: A store presented with `st_valid`=1 while `st_ready`=1 is accepted at that clock edge and `buf_count` rises by one. With the default configuration, `buf_full` becomes 1 and `st_ready` becomes 0 once 6 stores are pending.
- R3: While `buf_full` is 1, a store presented on the store port is not accepted. The count does not change, the store never reaches memory and it does not appear in load forwarding.
- R4: Stores leave on the memory port strictly in acceptance order, with address, data and byte enables unchanged.
- R5: An entry whose page (address bits `[ADDR_W-1:PAGE_BITS]`) differs from the page of the last drained store, or that is the first drained after reset, completes its drain `SLOW_CYCLES` clock edges after it reaches the head of the queue, given `mem_ready`=1 throughout.
- R6: An entry on the same page as the last drained store is offered immediately. Back-to-back same-page entries retire on consecutive clock edges while `mem_ready`=1.
- R7: While `mem_valid`=1 and `mem_ready`=0, the memory outputs stay stable and the entry is not removed.
- R8: Load forwarding compares word addresses (bits `[ADDR_W-1:2]` for a 32-bit data path). Bit b of `ld_fwd_mask` is 1 when some pending entry for that word has byte enable b set, and byte b of `ld_fwd_data` then holds that byte from the youngest such entry. Bytes with a clear mask bit read as zero. The result is combinational and never stalls the port.
- R9: With `SIMPLE`=1, the buffer holds 4 entries and every drain takes `SLOW_CYCLES` edges regardless of page, so with `mem_ready`=1 consecutive drains are 5 cycles apart by default.
- R10: A store accepted in the same cycle that an entry drains leaves `buf_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| st_valid | input | 1 | Core presents a store |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_ready | output | 1 | Store accepted this cycle when high; low means stall |
| ld_addr | input | ADDR_W | Load address for forwarding lookup |
| ld_fwd_mask | output | DATA_W/8 | Bytes supplied by pending stores |
| ld_fwd_data | output | DATA_W | Forwarded bytes, youngest wins |
| mem_valid | output | 1 | Head entry offered to memory |
| mem_addr | output | ADDR_W | Drain address |
| mem_data | output | DATA_W | Drain data |
| mem_be | output | DATA_W/8 | Drain byte enables |
| mem_ready | input | 1 | Memory accepts the offered store |
| buf_full | output | 1 | All slots occupied |
| buf_empty | output | 1 | No slot occupied |
| buf_count | output | $clog2(depth+1) | Number of pending stores |

## Verification
On every cycle the assertions check that the occupancy bound and the push/pop accounting hold. They also check that a full buffer does not take new stores, that an offer held against a stalled memory stays stable, and that a page-changing drain never comes before its wait has elapsed. They further check that a same-page successor follows a retirement on the next cycle, and that unforwarded bytes read as zero. Only the bench scenarios can show the exact drain latencies measured from acceptance, the full program order of data leaving the port, and the youngest-wins byte merge over overlapping stores. The same holds for the reduced four-slot variant and its uniform drain spacing.

// File: rtl/page_wbuf_pkg.sv
package page_wbuf_pkg;

  // Slot count actually built: the reduced variant always uses four slots.
  function automatic int slot_count(input int simple, input int depth);
    return (simple != 0) ? 4 : depth;
  endfunction

  // Width needed to hold the values 0..n.
  function automatic int span_bits(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/pwb_queue.sv
module pwb_queue #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 6,
  localparam int BW   = DW / 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = page_wbuf_pkg::span_bits(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     push,
  input  logic [AW-1:0]            push_addr,
  input  logic [DW-1:0]            push_data,
  input  logic [BW-1:0]            push_be,
  input  logic                     pop,
  output logic [AW-1:0]            head_addr,
  output logic [DW-1:0]            head_data,
  output logic [BW-1:0]            head_be,
  output logic                     full,
  output logic                     empty,
  output logic [CW-1:0]            count,
  output logic [PW-1:0]            rd_ptr,
  output logic [DEPTH-1:0][AW-1:0] ent_addr,
  output logic [DEPTH-1:0][DW-1:0] ent_data,
  output logic [DEPTH-1:0][BW-1:0] ent_be
);

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [PW-1:0] rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  logic [DEPTH-1:0][AW-1:0] addr_q;
  logic [DEPTH-1:0][DW-1:0] data_q;
  logic [DEPTH-1:0][BW-1:0] be_q;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = bump(wr_ptr_q);
    if (do_pop)  rd_ptr_d = bump(rd_ptr_q);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  // Payload storage: written only on an accepted store, no reset needed.
  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    logic slot_we;
    assign slot_we = do_push && (wr_ptr_q == PW'(s));
    always_ff @(posedge clk) begin
      if (slot_we) begin
        addr_q[s] <= push_addr;
        data_q[s] <= push_data;
        be_q[s]   <= push_be;
      end
    end
  end

  assign head_addr = addr_q[rd_ptr_q];
  assign head_data = data_q[rd_ptr_q];
  assign head_be   = be_q[rd_ptr_q];
  assign count     = cnt_q;
  assign rd_ptr    = rd_ptr_q;
  assign ent_addr  = addr_q;
  assign ent_data  = data_q;
  assign ent_be    = be_q;

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  assert_count_track_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !full && !empty) |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/pwb_drain.sv
module pwb_drain #(
  parameter int AW          = 32,
  parameter int PAGE_BITS   = 12,
  parameter int SLOW_CYCLES = 5,
  parameter bit SIMPLE      = 1'b0,
  localparam int EW         = page_wbuf_pkg::span_bits(SLOW_CYCLES),
  localparam int GW         = AW - PAGE_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          empty,
  input  logic [AW-1:0] head_addr,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic          pop
);

  localparam logic [EW-1:0] WAIT_MAX = EW'(SLOW_CYCLES - 1);

  logic [EW-1:0] elapsed_q, elapsed_d;
  logic [GW-1:0] last_pg_q, last_pg_d;
  logic          seen_q, seen_d;
  logic          same_pg;
  logic [EW-1:0] need;
  logic [GW-1:0] head_pg;

  assign head_pg = head_addr[AW-1:PAGE_BITS];

  if (SIMPLE) begin : g_flat
    assign same_pg = 1'b0;
  end else begin : g_paged
    assign same_pg = seen_q && (head_pg == last_pg_q);
  end

  assign need      = same_pg ? '0 : WAIT_MAX;
  assign mem_valid = ~empty && (elapsed_q >= need);
  assign pop       = mem_valid & mem_ready;

  always_comb begin
    elapsed_d = elapsed_q;
    last_pg_d = last_pg_q;
    seen_d    = seen_q;
    if (pop) begin
      elapsed_d = '0;
      last_pg_d = head_pg;
      seen_d    = 1'b1;
    end else if (!empty && elapsed_q < WAIT_MAX) begin
      elapsed_d = elapsed_q + EW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elapsed_q <= '0;
      last_pg_q <= '0;
      seen_q    <= 1'b0;
    end else begin
      elapsed_q <= elapsed_d;
      last_pg_q <= last_pg_d;
      seen_q    <= seen_d;
    end
  end

  // Independent wait tracker for the slow-drain check.
  logic [15:0] chk_wait;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             chk_wait <= '0;
    else if (pop)                           chk_wait <= '0;
    else if (!empty && chk_wait != 16'hFFFF) chk_wait <= chk_wait + 16'd1;
  end

  assert_slow_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !same_pg) |-> (chk_wait >= 16'(SLOW_CYCLES - 1)));

  assert_hold_offer_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(head_addr)));

endmodule

// File: rtl/pwb_fwd.sv
module pwb_fwd #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int DEPTH = 6,
  localparam int BW   = DW / 8,
  localparam int OFF  = (BW > 1) ? $clog2(BW) : 0,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = page_wbuf_pkg::span_bits(DEPTH)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DEPTH-1:0][AW-1:0] ent_addr,
  input  logic [DEPTH-1:0][DW-1:0] ent_data,
  input  logic [DEPTH-1:0][BW-1:0] ent_be,
  input  logic [PW-1:0]            rd_ptr,
  input  logic [CW-1:0]            count,
  input  logic [AW-1:0]            ld_addr,
  output logic [BW-1:0]            fwd_mask,
  output logic [DW-1:0]            fwd_data
);

  // Walk from oldest to youngest; a later match overwrites an earlier one.
  always_comb begin
    int idx;
    fwd_mask = '0;
    fwd_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = int'(rd_ptr) + k;
      if (idx >= DEPTH) idx = idx - DEPTH;
      if ((k < int'(count)) && (ent_addr[idx][AW-1:OFF] == ld_addr[AW-1:OFF])) begin
        for (int b = 0; b < BW; b++) begin
          if (ent_be[idx][b]) begin
            fwd_mask[b]        = 1'b1;
            fwd_data[8*b +: 8] = ent_data[idx][8*b +: 8];
          end
        end
      end
    end
  end

  assert_fwd_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> (fwd_mask == '0 && fwd_data == '0));

endmodule

// File: rtl/page_wbuf.sv
module page_wbuf #(
  parameter int ADDR_W      = 32,
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 6,
  parameter int PAGE_BITS   = 12,
  parameter int SLOW_CYCLES = 5,
  parameter bit SIMPLE      = 1'b0,
  localparam int BE_W       = DATA_W / 8,
  localparam int SLOTS      = page_wbuf_pkg::slot_count(int'(SIMPLE), DEPTH),
  localparam int CNT_W      = page_wbuf_pkg::span_bits(SLOTS),
  localparam int PTR_W      = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic [BE_W-1:0]   ld_fwd_mask,
  output logic [DATA_W-1:0] ld_fwd_data,
  output logic              mem_valid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  input  logic              mem_ready,
  output logic              buf_full,
  output logic              buf_empty,
  output logic [CNT_W-1:0]  buf_count
);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync;
  logic       rst_l;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_l = rst_sync[1];

  logic                            q_push, q_pop, q_full, q_empty;
  logic [CNT_W-1:0]                q_count;
  logic [PTR_W-1:0]                q_rd;
  logic [SLOTS-1:0][ADDR_W-1:0]    q_addr;
  logic [SLOTS-1:0][DATA_W-1:0]    q_data;
  logic [SLOTS-1:0][BE_W-1:0]      q_be;

  assign st_ready = ~q_full;
  assign q_push   = st_valid & st_ready;

  pwb_queue #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(SLOTS)) u_queue (
    .clk(clk), .rst_n(rst_l),
    .push(q_push), .push_addr(st_addr), .push_data(st_data), .push_be(st_be),
    .pop(q_pop),
    .head_addr(mem_addr), .head_data(mem_data), .head_be(mem_be),
    .full(q_full), .empty(q_empty), .count(q_count), .rd_ptr(q_rd),
    .ent_addr(q_addr), .ent_data(q_data), .ent_be(q_be)
  );

  pwb_drain #(.AW(ADDR_W), .PAGE_BITS(PAGE_BITS), .SLOW_CYCLES(SLOW_CYCLES),
              .SIMPLE(SIMPLE)) u_drain (
    .clk(clk), .rst_n(rst_l),
    .empty(q_empty), .head_addr(mem_addr), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .pop(q_pop)
  );

  pwb_fwd #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(SLOTS)) u_fwd (
    .clk(clk), .rst_n(rst_l),
    .ent_addr(q_addr), .ent_data(q_data), .ent_be(q_be),
    .rd_ptr(q_rd), .count(q_count), .ld_addr(ld_addr),
    .fwd_mask(ld_fwd_mask), .fwd_data(ld_fwd_data)
  );

  assign buf_full  = q_full;
  assign buf_empty = q_empty;
  assign buf_count = q_count;

  // Second-oldest entry, used only by the back-to-back check.
  logic [PTR_W-1:0]  chk_nxt;
  logic [ADDR_W-1:0] chk_nxt_addr;
  assign chk_nxt      = (q_rd == PTR_W'(SLOTS - 1)) ? '0 : q_rd + PTR_W'(1);
  assign chk_nxt_addr = q_addr[chk_nxt];

  assert_full_ignore_R3: assert property (@(posedge clk) disable iff (!rst_l)
    (buf_full && !(mem_valid && mem_ready)) |=> (buf_count == $past(buf_count)));

  assert_back_to_back_R6: assert property (@(posedge clk) disable iff (!rst_l)
    (!SIMPLE && mem_valid && mem_ready && q_count > CNT_W'(1) &&
     chk_nxt_addr[ADDR_W-1:PAGE_BITS] == mem_addr[ADDR_W-1:PAGE_BITS]) |=> mem_valid);

endmodule

// File: tb/sim_page_wbuf.sv
module sim_page_wbuf;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // Device under test: default configuration
  logic        st_valid, st_ready, mem_valid, mem_ready, buf_full, buf_empty;
  logic [31:0] st_addr, st_data, ld_addr, ld_fwd_data, mem_addr, mem_data;
  logic [3:0]  st_be, ld_fwd_mask, mem_be;
  logic [2:0]  buf_count;

  page_wbuf u0 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .st_ready(st_ready), .ld_addr(ld_addr), .ld_fwd_mask(ld_fwd_mask),
    .ld_fwd_data(ld_fwd_data), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .mem_ready(mem_ready),
    .buf_full(buf_full), .buf_empty(buf_empty), .buf_count(buf_count)
  );

  // Reduced variant
  logic        s_valid, s_ready, s_mvalid, s_mready, s_full, s_empty;
  logic [31:0] s_addr, s_data, s_fdata, s_maddr, s_mdata;
  logic [3:0]  s_be, s_fmask, s_mbe;
  logic [2:0]  s_count;

  page_wbuf #(.SIMPLE(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n),
    .st_valid(s_valid), .st_addr(s_addr), .st_data(s_data), .st_be(s_be),
    .st_ready(s_ready), .ld_addr(32'h0), .ld_fwd_mask(s_fmask),
    .ld_fwd_data(s_fdata), .mem_valid(s_mvalid), .mem_addr(s_maddr),
    .mem_data(s_mdata), .mem_be(s_mbe), .mem_ready(s_mready),
    .buf_full(s_full), .buf_empty(s_empty), .buf_count(s_count)
  );

  // Drain logs
  int          cyc = 0;
  logic [31:0] lg_addr [0:63];
  logic [31:0] lg_data [0:63];
  logic [3:0]  lg_be   [0:63];
  int          lg_cyc  [0:63];
  int          lg_n = 0;
  int          s_cyc   [0:15];
  int          s_n = 0;

  always @(posedge clk) begin
    if (mem_valid && mem_ready && lg_n < 64) begin
      lg_addr[lg_n] <= mem_addr;
      lg_data[lg_n] <= mem_data;
      lg_be[lg_n]   <= mem_be;
      lg_cyc[lg_n]  <= cyc;
      lg_n          <= lg_n + 1;
    end
    if (s_mvalid && s_mready && s_n < 16) begin
      s_cyc[s_n] <= cyc;
      s_n        <= s_n + 1;
    end
    cyc <= cyc + 1;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  // Present one store for one edge; returns the edge index of acceptance attempt.
  task automatic put(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                     output int edge_no);
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = be;
    tick();
    edge_no = cyc - 1;
    st_valid = 1'b0;
  endtask

  task automatic wait_log(input int target, input string tag);
    int n;
    n = 0;
    while (lg_n < target && n < 200) begin tick(); n++; end
    chk(lg_n >= target, tag, lg_n, target);
  endtask

  task automatic t_reset();
    chk(buf_empty === 1'b1, "R1 empty", 32'(buf_empty), 1);
    chk(buf_full === 1'b0, "R1 full", 32'(buf_full), 0);
    chk(buf_count === 3'd0, "R1 count", 32'(buf_count), 0);
    chk(mem_valid === 1'b0, "R1 mem_valid", 32'(mem_valid), 0);
    chk(st_ready === 1'b1, "R1 st_ready", 32'(st_ready), 1);
  endtask

  task automatic t_same_page_burst();
    int e0, e;
    int base;
    base = lg_n;
    mem_ready = 1'b1;
    put(32'h0000_1000, 32'hA0A0_0001, 4'hF, e0);
    chk(buf_count === 3'd1, "R2 count after store", 32'(buf_count), 1);
    put(32'h0000_1004, 32'hA0A0_0002, 4'hF, e);
    put(32'h0000_1010, 32'hA0A0_0003, 4'hF, e);
    put(32'h0000_1FFC, 32'hA0A0_0004, 4'hF, e);
    wait_log(base + 4, "R6 burst drained");
    chk(lg_cyc[base] - e0 == 5, "R5 first drain latency", lg_cyc[base] - e0, 5);
    for (int i = 1; i < 4; i++)
      chk(lg_cyc[base+i] - lg_cyc[base+i-1] == 1, "R6 same-page spacing",
          lg_cyc[base+i] - lg_cyc[base+i-1], 1);
  endtask

  task automatic t_page_change();
    int ea, e;
    int base;
    base = lg_n;
    put(32'h0000_5000, 32'hB000_0001, 4'hF, ea);
    put(32'h0000_5ABC, 32'hB000_0002, 4'hF, e);
    put(32'h0000_1000, 32'hB000_0003, 4'hF, e);
    wait_log(base + 3, "R5 page-change drained");
    chk(lg_cyc[base] - ea == 5, "R5 new page latency", lg_cyc[base] - ea, 5);
    chk(lg_cyc[base+1] - lg_cyc[base] == 1, "R6 hit after miss",
        lg_cyc[base+1] - lg_cyc[base], 1);
    chk(lg_cyc[base+2] - lg_cyc[base+1] == 5, "R5 return to old page",
        lg_cyc[base+2] - lg_cyc[base+1], 5);
  endtask

  task automatic t_full_forward();
    logic [31:0] ea [0:5];
    logic [31:0] ed [0:5];
    logic [3:0]  eb [0:5];
    int e, base;
    ea[0] = 32'h2000; ed[0] = 32'h1122_3344; eb[0] = 4'b1111;
    ea[1] = 32'h2004; ed[1] = 32'hAAAA_AAAA; eb[1] = 4'b0011;
    ea[2] = 32'h2000; ed[2] = 32'h5566_7788; eb[2] = 4'b0100;
    ea[3] = 32'h2008; ed[3] = 32'h9999_9999; eb[3] = 4'b1000;
    ea[4] = 32'h2000; ed[4] = 32'hCAFE_BABE; eb[4] = 4'b0001;
    ea[5] = 32'h3000; ed[5] = 32'h0102_0304; eb[5] = 4'b1111;
    base = lg_n;
    mem_ready = 1'b0;
    for (int i = 0; i < 6; i++) put(ea[i], ed[i], eb[i], e);
    chk(buf_full === 1'b1, "R2 full at six", 32'(buf_full), 1);
    chk(buf_count === 3'd6, "R2 count six", 32'(buf_count), 6);
    chk(st_ready === 1'b0, "R2 ready low when full", 32'(st_ready), 0);
    // Store attempts while full
    st_valid = 1'b1; st_addr = 32'h2000; st_data = 32'hDEAD_BEEF; st_be = 4'hF;
    tick(); tick(); tick();
    st_valid = 1'b0;
    chk(buf_count === 3'd6, "R3 count while full", 32'(buf_count), 6);
    // Forwarding
    ld_addr = 32'h2000; #1;
    chk(ld_fwd_mask === 4'hF, "R8 mask word0", 32'(ld_fwd_mask), 32'hF);
    chk(ld_fwd_data === 32'h1166_33BE, "R8 merge youngest / R3 dropped store",
        ld_fwd_data, 32'h1166_33BE);
    ld_addr = 32'h2002; #1;
    chk(ld_fwd_data === 32'h1166_33BE, "R8 offset ignored", ld_fwd_data, 32'h1166_33BE);
    ld_addr = 32'h2004; #1;
    chk(ld_fwd_mask === 4'b0011 && ld_fwd_data === 32'h0000_AAAA, "R8 partial",
        ld_fwd_data, 32'h0000_AAAA);
    ld_addr = 32'h4000; #1;
    chk(ld_fwd_mask === 4'h0 && ld_fwd_data === 32'h0, "R8 miss", ld_fwd_data, 0);
    // Memory stall hold
    tick(); tick(); tick(); tick(); tick();
    chk(mem_valid === 1'b1 && mem_addr === 32'h2000 && mem_data === 32'h1122_3344,
        "R7 offer held", mem_data, 32'h1122_3344);
    tick(); tick();
    chk(mem_valid === 1'b1 && mem_addr === 32'h2000 && buf_count === 3'd6,
        "R7 still held", mem_addr, 32'h2000);
    mem_ready = 1'b1;
    wait_log(base + 6, "R4 all drained");
    tick(); tick();
    for (int i = 0; i < 6; i++)
      chk(lg_addr[base+i] === ea[i] && lg_data[base+i] === ed[i] && lg_be[base+i] === eb[i],
          "R4 order and content", lg_data[base+i], ed[i]);
    chk(lg_n == base + 6, "R3 dropped store never drained", lg_n - base, 6);
    chk(buf_empty === 1'b1, "R4 empty after drain", 32'(buf_empty), 1);
  endtask

  task automatic t_concurrent();
    int e, base;
    base = lg_n;
    mem_ready = 1'b0;
    put(32'h3010, 32'hC000_0001, 4'hF, e);
    put(32'h3020, 32'hC000_0002, 4'hF, e);
    chk(mem_valid === 1'b1 && buf_count === 3'd2, "R6 hit offered at once",
        32'(buf_count), 2);
    mem_ready = 1'b1;
    put(32'h3030, 32'hC000_0003, 4'hF, e);
    chk(buf_count === 3'd2, "R10 push with pop", 32'(buf_count), 2);
    wait_log(base + 3, "R10 drained");
    chk(lg_data[base+2] === 32'hC000_0003, "R10 concurrent store kept",
        lg_data[base+2], 32'hC000_0003);
  endtask

  task automatic t_simple();
    int n;
    s_mready = 1'b0;
    for (int i = 0; i < 4; i++) begin
      s_valid = 1'b1; s_addr = 32'h7000 + 32'(4*i); s_data = 32'(i); s_be = 4'hF;
      tick();
    end
    s_valid = 1'b0;
    chk(s_full === 1'b1 && s_count === 3'd4, "R9 four slots", 32'(s_count), 4);
    s_mready = 1'b1;
    n = 0;
    while (s_n < 4 && n < 200) begin tick(); n++; end
    chk(s_n == 4, "R9 drained", s_n, 4);
    for (int i = 1; i < 4; i++)
      chk(s_cyc[i] - s_cyc[i-1] == 5, "R9 uniform slow drain",
          s_cyc[i] - s_cyc[i-1], 5);
  endtask

  initial begin
    st_valid = 0; st_addr = 0; st_data = 0; st_be = 0; ld_addr = 0; mem_ready = 0;
    s_valid = 0; s_addr = 0; s_data = 0; s_be = 0; s_mready = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) tick();
    t_reset();
    t_same_page_burst();
    t_page_change();
    t_full_forward();
    t_concurrent();
    t_simple();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule